// File: doc/BRIEF.md
# Buffered Lag-Sweep Cross-Correlator

This block measures how closely two signed sample sequences match when one is shifted against the other. A caller signals a run by taking `start` high and then low again. On the falling edge the block begins to store exactly N pairs of samples, one pair per clock, into two private buffers. Once both sequences are stored, the block sweeps every lag from -D to +D through a single multiply-accumulate datapath. It spends N cycles on each lag.

When a lag's sum is finished, the block presents the correlation value on `corr_out`. It presents the matching signed lag on `lag_out` at the same time, and raises `complete` for that one cycle. After the last lag the block returns to idle and accepts a new start. The sample width W may be 16 to 18 bits. The length N may be 256, 512, 1024 or 2048. The maximum lag D may be 1 to 16.

Top module: `xcorr_lag_sweep`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle with `in_ready` = 1 and `complete` = 0. Any partial load or sweep is abandoned, so no `complete` follows until a new start.
- R2: A load begins only when `start` is sampled low at a clock edge after being sampled high at the previous edge while idle. The first pair is taken at the next rising edge, and the following N-1 pairs at the edges after it. Holding `start` high starts nothing.
- R3: The value for lag k equals the sum over n of x[n+k]·y[n], where x[i] is the i-th pair's `x_in` and y[i] its `y_in` (0-based). Terms with n or n+k outside 0..N-1 contribute zero, with no wrap-around.
- R4: `corr_out` is a two's complement value of 2W+log2(N) bits and is exact for every input. This includes all samples of both sequences at the most negative code.
- R5: After a load, `complete` pulses exactly 2D+1 times, each pulse one cycle long. `lag_out`, a two's complement value of ceil(log2(D+1))+1 bits, runs in ascending order from -D to +D across those pulses.
- R6: Consecutive `complete` pulses of one sweep are exactly N clock cycles apart.
- R7: `in_ready` is 1 while idle and while loading. It is 0 from the cycle after the N-th pair is taken until the final `complete` pulse, and 1 again in the cycle after that pulse.
- R8: Falling edges of `start` that occur during a load or a sweep are ignored: the stored samples, the values and the number of pulses are unchanged.
- R9: Samples are W-bit two's complement with the MSB as sign, so mixed positive and negative inputs give signed products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Run request; its falling edge while idle starts a load |
| x_in | input | W | Sample of the first (shifted) sequence |
| y_in | input | W | Sample of the second (reference) sequence |
| in_ready | output | 1 | High while the block can take a sequence |
| corr_out | output | 2W+log2(N) | Signed correlation value for `lag_out` |
| lag_out | output | ceil(log2(D+1))+1 | Signed lag of the current value |
| complete | output | 1 | One-cycle strobe marking `corr_out`/`lag_out` valid |

## Verification
The bench builds the block with W = 16, N = 256 (the shortest legal length) and D = 3. A full load plus a seven-lag sweep therefore fits in about two thousand cycles, and every lag of several whole runs can be compared against sums the bench computes itself. The short length lets impulses placed at the first and last sample positions expose any wrap-around. It also lets all-most-negative sequences reach the largest magnitude the accumulator must hold, and lets start edges injected mid-load and mid-sweep show whether they disturb a run.

// File: rtl/xc_pkg.sv
`timescale 1ns/1ps
package xc_pkg;

    // Phase of a correlation run.
    typedef enum logic [1:0] {
        XC_IDLE  = 2'd0,
        XC_FILL  = 2'd1,
        XC_SWEEP = 2'd2,
        XC_FLUSH = 2'd3
    } xc_phase_e;

    // Per-cycle tag that travels beside a buffer read.
    typedef struct packed {
        logic live;       // a pair was issued this cycle
        logic pair_ok;    // both indices inside the sequence
        logic first;      // first index of a lag
        logic last;       // last index of a lag
        logic final_lag;  // lag is the highest of the sweep
    } xc_tap_t;

    // Width of the signed lag tag able to hold -d..+d.
    function automatic int xc_lag_w(input int d);
        return $clog2(d + 1) + 1;
    endfunction

    // Accumulator width that cannot overflow for n products of w-bit samples.
    function automatic int xc_acc_w(input int w, input int n);
        return 2 * w + $clog2(n);
    endfunction

endpackage

// File: rtl/xc_fall_det.sv
`timescale 1ns/1ps
module xc_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic fall
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign fall = level_q & ~level;
endmodule

// File: rtl/xc_sample_buf.sv
`timescale 1ns/1ps
module xc_sample_buf #(
    parameter int W = 16,
    parameter int N = 256
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [$clog2(N)-1:0]   waddr,
    input  logic signed [W-1:0]    wdata,
    input  logic [$clog2(N)-1:0]   raddr,
    output logic signed [W-1:0]    rdata
);
    logic signed [W-1:0] store [N];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata <= store[raddr];
    end
endmodule

// File: rtl/xc_ctrl.sv
`timescale 1ns/1ps
module xc_ctrl
    import xc_pkg::*;
#(
    parameter int N = 256,
    parameter int D = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_fall,
    input  logic                          sweep_end,
    output logic                          in_ready,
    output logic                          we,
    output logic [$clog2(N)-1:0]          waddr,
    output logic [$clog2(N)-1:0]          rax,
    output logic [$clog2(N)-1:0]          ray,
    output xc_tap_t                       tap,
    output logic signed [xc_lag_w(D)-1:0] lag_issue
);
    localparam int IW = $clog2(N);
    localparam int LW = xc_lag_w(D);
    localparam int AW = IW + 2;
    localparam logic [IW-1:0]        IDX_LAST = IW'(N - 1);
    localparam logic signed [LW-1:0] LAG_HI   = LW'(D);
    localparam logic signed [LW-1:0] LAG_LO   = -LAG_HI;
    localparam logic signed [AW-1:0] N_LIM    = AW'(N);

    xc_phase_e              phase;
    logic [IW-1:0]          widx;
    logic [IW-1:0]          n_idx;
    logic signed [LW-1:0]   lag_cur;
    logic signed [AW-1:0]   xa;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= XC_IDLE;
            widx    <= '0;
            n_idx   <= '0;
            lag_cur <= LAG_LO;
        end else begin
            case (phase)
                XC_IDLE: begin
                    if (start_fall) begin
                        phase <= XC_FILL;
                        widx  <= '0;
                    end
                end
                XC_FILL: begin
                    widx <= widx + IW'(1);
                    if (widx == IDX_LAST) begin
                        phase   <= XC_SWEEP;
                        n_idx   <= '0;
                        lag_cur <= LAG_LO;
                    end
                end
                XC_SWEEP: begin
                    if (n_idx == IDX_LAST) begin
                        n_idx <= '0;
                        if (lag_cur == LAG_HI) phase <= XC_FLUSH;
                        else                   lag_cur <= lag_cur + LW'(1);
                    end else begin
                        n_idx <= n_idx + IW'(1);
                    end
                end
                XC_FLUSH: begin
                    if (sweep_end) phase <= XC_IDLE;
                end
                default: phase <= XC_IDLE;
            endcase
        end
    end

    // Index into the shifted sequence: n + lag, kept wide enough for sign.
    assign xa = $signed({2'b00, n_idx}) + $signed({{(AW - LW){lag_cur[LW-1]}}, lag_cur});

    always_comb begin
        in_ready      = (phase == XC_IDLE) || (phase == XC_FILL);
        we            = (phase == XC_FILL);
        waddr         = widx;
        rax           = xa[IW-1:0];
        ray           = n_idx;
        lag_issue     = lag_cur;
        tap.live      = (phase == XC_SWEEP);
        tap.pair_ok   = !xa[AW-1] && (xa < N_LIM);
        tap.first     = (n_idx == '0);
        tap.last      = (n_idx == IDX_LAST);
        tap.final_lag = (lag_cur == LAG_HI);
    end
endmodule

// File: rtl/xc_mac.sv
`timescale 1ns/1ps
module xc_mac
    import xc_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 256,
    parameter int D = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  xc_tap_t                          tap_i,
    input  logic signed [xc_lag_w(D)-1:0]    lag_i,
    input  logic signed [W-1:0]              xd,
    input  logic signed [W-1:0]              yd,
    output logic signed [xc_acc_w(W,N)-1:0]  corr_o,
    output logic signed [xc_lag_w(D)-1:0]    lag_o,
    output logic                             complete_o,
    output logic                             final_o
);
    localparam int LW = xc_lag_w(D);
    localparam int RW = xc_acc_w(W, N);
    localparam int PW = 2 * W;

    xc_tap_t                tap_q;
    logic signed [LW-1:0]   lag_q;
    logic signed [PW-1:0]   prod;
    logic signed [RW-1:0]   prod_ext;
    logic signed [RW-1:0]   acc;
    logic signed [RW-1:0]   sum;

    assign prod     = xd * yd;
    assign prod_ext = {{(RW - PW){prod[PW-1]}}, prod};
    assign sum      = (tap_q.first ? '0 : acc) + (tap_q.pair_ok ? prod_ext : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q      <= '0;
            lag_q      <= '0;
            acc        <= '0;
            corr_o     <= '0;
            lag_o      <= '0;
            complete_o <= 1'b0;
            final_o    <= 1'b0;
        end else begin
            tap_q      <= tap_i;
            lag_q      <= lag_i;
            complete_o <= 1'b0;
            final_o    <= 1'b0;
            if (tap_q.live) begin
                acc <= sum;
                if (tap_q.last) begin
                    corr_o     <= sum;
                    lag_o      <= lag_q;
                    complete_o <= 1'b1;
                    final_o    <= tap_q.final_lag;
                end
            end
        end
    end
endmodule

// File: rtl/xcorr_lag_sweep.sv
`timescale 1ns/1ps
module xcorr_lag_sweep
    import xc_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 256,
    parameter int D = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic signed [W-1:0]              x_in,
    input  logic signed [W-1:0]              y_in,
    output logic                             in_ready,
    output logic signed [xc_acc_w(W,N)-1:0]  corr_out,
    output logic signed [xc_lag_w(D)-1:0]    lag_out,
    output logic                             complete
);
    localparam int IW = $clog2(N);
    localparam int LW = xc_lag_w(D);

    logic                  start_fall;
    logic                  sweep_end;
    logic                  final_flag;
    logic                  we;
    logic [IW-1:0]         waddr;
    logic [IW-1:0]         rax;
    logic [IW-1:0]         ray;
    xc_tap_t               tap;
    logic signed [LW-1:0]  lag_issue;

    logic signed [W-1:0]   buf_wdata [2];
    logic [IW-1:0]         buf_raddr [2];
    logic signed [W-1:0]   buf_rdata [2];

    xc_fall_det u_fall (
        .clk   (clk),
        .rst   (rst),
        .level (start),
        .fall  (start_fall)
    );

    xc_ctrl #(.N(N), .D(D)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_fall (start_fall),
        .sweep_end  (sweep_end),
        .in_ready   (in_ready),
        .we         (we),
        .waddr      (waddr),
        .rax        (rax),
        .ray        (ray),
        .tap        (tap),
        .lag_issue  (lag_issue)
    );

    assign buf_wdata[0] = x_in;
    assign buf_wdata[1] = y_in;
    assign buf_raddr[0] = rax;
    assign buf_raddr[1] = ray;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        xc_sample_buf #(.W(W), .N(N)) u_buf (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (buf_wdata[b]),
            .raddr (buf_raddr[b]),
            .rdata (buf_rdata[b])
        );
    end

    xc_mac #(.W(W), .N(N), .D(D)) u_mac (
        .clk        (clk),
        .rst        (rst),
        .tap_i      (tap),
        .lag_i      (lag_issue),
        .xd         (buf_rdata[0]),
        .yd         (buf_rdata[1]),
        .corr_o     (corr_out),
        .lag_o      (lag_out),
        .complete_o (complete),
        .final_o    (final_flag)
    );

    assign sweep_end = complete & final_flag;
endmodule

// File: rtl/xcorr_lag_sweep_chk.sv
`timescale 1ns/1ps
module xcorr_lag_sweep_chk
    import xc_pkg::*;
#(
    parameter int N = 256,
    parameter int D = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_ready,
    input logic signed [xc_lag_w(D)-1:0] lag_out,
    input logic                          complete
);
    localparam int LW = xc_lag_w(D);
    localparam int GW = $clog2(N) + 2;
    localparam logic signed [LW-1:0] LAG_HI = LW'(D);
    localparam logic signed [LW-1:0] LAG_LO = -LAG_HI;
    localparam logic [GW-1:0]        GAP_N  = GW'(N);
    localparam logic [GW-1:0]        GAP_MX = '1;

    logic                  rst_seen;
    logic signed [LW-1:0]  exp_lag;
    logic [GW-1:0]         gap;
    logic                  armed;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        // R1: the edge after a reset edge shows the idle outputs
        if (rst_seen == 1'b1) begin
            p_reset_idle_r1: assert (in_ready && !complete)
                else $error("reset did not leave the block idle");
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_lag <= LAG_LO;
            gap     <= '0;
            armed   <= 1'b0;
        end else if (complete) begin
            exp_lag <= (lag_out == LAG_HI) ? LAG_LO : lag_out + LW'(1);
            gap     <= GW'(1);
            armed   <= (lag_out != LAG_HI);
        end else if (gap != GAP_MX) begin
            gap <= gap + GW'(1);
        end
    end

    // R5: lags come out in ascending order, wrapping to -D for the next run
    p_lag_order_r5: assert property (@(posedge clk) disable iff (rst)
        complete |-> lag_out == exp_lag);

    // R5: each strobe lasts one cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        complete |=> !complete);

    // R6: strobes inside one sweep are N cycles apart
    p_lag_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (complete && armed) |-> gap == GAP_N);

    // R7: not ready while results are being produced
    p_busy_ready_r7: assert property (@(posedge clk) disable iff (rst)
        complete |-> !in_ready);

    // R7: ready again right after the last lag
    p_ready_after_r7: assert property (@(posedge clk) disable iff (rst)
        (complete && lag_out == LAG_HI) |=> in_ready);
endmodule

bind xcorr_lag_sweep xcorr_lag_sweep_chk #(.N(N), .D(D)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .lag_out  (lag_out),
    .complete (complete)
);

// File: tb/test_xcorr_lag_sweep.sv
`timescale 1ns/1ps
module test_xcorr_lag_sweep;
    import xc_pkg::*;

    localparam int W  = 16;
    localparam int N  = 256;
    localparam int D  = 3;
    localparam int LW = xc_lag_w(D);
    localparam int RW = xc_acc_w(W, N);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic signed [W-1:0]   x_in = '0;
    logic signed [W-1:0]   y_in = '0;
    logic                  in_ready;
    logic signed [RW-1:0]  corr_out;
    logic signed [LW-1:0]  lag_out;
    logic                  complete;

    int n_checks = 0;
    int n_fail   = 0;
    int xs [N];
    int ys [N];

    always #2.5 clk = ~clk;

    xcorr_lag_sweep #(.W(W), .N(N), .D(D)) i_xcorr_lag_sweep (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .x_in     (x_in),
        .y_in     (y_in),
        .in_ready (in_ready),
        .corr_out (corr_out),
        .lag_out  (lag_out),
        .complete (complete)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint expect_corr(input int k);
        longint s = 0;
        for (int n = 0; n < N; n++) begin
            if (n + k >= 0 && n + k < N)
                s += longint'(xs[n + k]) * longint'(ys[n]);
        end
        return s;
    endfunction

    // One full run: optional long start hold, load, then collect every lag.
    task automatic run_sweep(input int hold, input bit glitch, input string req);
        int  got   = 0;
        int  since = 0;
        int  bad   = 0;
        @(negedge clk) start = 1'b1;
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            if (complete || !in_ready) bad++;
        end
        if (hold > 0) check(bad == 0, "R2", "start held high began a run", bad, 0);
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            x_in = xs[i][W-1:0];
            y_in = ys[i][W-1:0];
            if (glitch && i == 50) start = 1'b1;
            if (glitch && i == 51) start = 1'b0;
            if (i == 0) check(in_ready == 1'b1, "R7", "in_ready during load", in_ready, 1);
        end
        @(negedge clk);
        start = 1'b0;
        check(in_ready == 1'b0, "R7", "in_ready after load", in_ready, 0);
        for (int c = 0; c < (2 * D + 1) * N + 50 && got < 2 * D + 1; c++) begin
            @(negedge clk);
            if (glitch && c == 100) start = 1'b1;
            if (glitch && c == 101) start = 1'b0;
            since++;
            if (complete) begin
                check(int'(lag_out) == got - D, "R5", "lag order", int'(lag_out), got - D);
                check(longint'(corr_out) == expect_corr(got - D), req, "correlation value",
                      longint'(corr_out), expect_corr(got - D));
                if (got > 0) check(since == N, "R6", "strobe spacing", since, N);
                if (glitch) check(1'b1, "R8", "mid-run start edge", 0, 0);
                got++;
                since = 0;
            end
        end
        check(got == 2 * D + 1, "R5", "number of strobes", got, 2 * D + 1);
        @(negedge clk);
        check(in_ready == 1'b1 && complete == 1'b0, "R7", "idle after sweep",
              {in_ready, complete}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(complete == 1'b0, "R1", "complete after reset", complete, 0);

        // R3: ramp against a folded pattern; start held high first (R2)
        for (int i = 0; i < N; i++) begin
            xs[i] = i - 128;
            ys[i] = (i * 7) % 61 - 30;
        end
        run_sweep(N + 40, 1'b0, "R3");

        // R3: interior impulses, only lag 3 nonzero
        for (int i = 0; i < N; i++) begin xs[i] = 0; ys[i] = 0; end
        xs[10] = 1000;
        ys[7]  = -3;
        run_sweep(0, 1'b0, "R3");

        // R3: impulses at the ends; any wrap would show at lags -1 and +1
        for (int i = 0; i < N; i++) begin xs[i] = 0; ys[i] = 0; end
        xs[0] = 5;      ys[N-1] = 7;
        xs[N-1] = 11;   ys[0] = 13;
        run_sweep(0, 1'b0, "R3");

        // R4: every sample at the most negative code
        for (int i = 0; i < N; i++) begin
            xs[i] = -(1 << (W - 1));
            ys[i] = -(1 << (W - 1));
        end
        run_sweep(0, 1'b0, "R4");

        // R9: mixed-sign pseudo-random samples spanning the full range
        for (int i = 0; i < N; i++) begin
            xs[i] = ((i * 12345 + 678) % 65536) - 32768;
            ys[i] = ((i * 40503 + 91) % 65536) - 32768;
        end
        run_sweep(0, 1'b0, "R9");

        // R8: same data, extra start falling edges during load and sweep
        run_sweep(0, 1'b1, "R8");

        // R1: reset in the middle of a load abandons it
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(in_ready == 1'b1 && complete == 1'b0, "R1", "idle after mid-load reset",
              {in_ready, complete}, 2);
        bad = 0;
        for (int c = 0; c < (2 * D + 2) * N; c++) begin
            @(negedge clk);
            if (complete || !in_ready) bad++;
        end
        check(bad == 0, "R1", "activity after reset abandon", bad, 0);

        // R3: a clean run still works after the abandoned one
        for (int i = 0; i < N; i++) begin
            xs[i] = (i % 5) - 2;
            ys[i] = 3 - (i % 7);
        end
        run_sweep(0, 1'b0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule